// File: doc/BRIEF.md
# Hash-Sampler Mode Router and Sequencer

This block runs one hashing or sampling job around a shared Keccak permutation engine. A one-cycle start pulse captures the requested mode and the input source. During the absorb phase the block passes beats from the chosen source (seed memory, polynomial memory reader or raw stream) to the engine. Absorption may span any number of segments. It ends only on a segment-end beat accepted while the absorb-last flag is high.

During the squeeze phase the engine's output stream goes to one of three sinks: the uniform (rejection) sampler, the noise (binomial) sampler, or the bypass port that writes hash results back to seed memory. The block counts output bytes down from the job length. It marks the last beat and its valid bytes. It then raises a done flag that stays high until the next accepted start. The permutation and the samplers sit outside this block.

Top module: `hs_router_seq`

## Requirements
- R1: Out of reset, `done_o` is 0, `eng_cfg_o` is 0, and every source ready, engine input valid, engine output ready and sink valid is 0.
- R2: A start pulse in the idle state is accepted only with a mode code from 0 to 4 and a source code from 0 to 2 (0 seed, 1 poly reader, 2 raw stream). Acceptance clears `done_o` on the next cycle. Any other code leaves every output unchanged.
- R3: A start pulse while a job is absorbing or squeezing is ignored. The engine configuration and the job length stay as captured.
- R4: `eng_cfg_o` follows the captured mode: mode 0 gives 0 (SHAKE128), mode 1 and mode 4 give 1 (SHAKE256), mode 2 gives 2 (SHA3-256), mode 3 gives 3 (SHA3-512).
- R5: While absorbing, only the captured source sees `eng_in_ready_i` on its ready output. `eng_in_data_o`, `eng_in_valid_o` and `eng_in_seg_end_o` carry that source's data, valid and last. Outside absorption all of these are 0.
- R6: A segment-end handshake with `absorb_last_i` low keeps the block absorbing. With it high the block moves to squeezing. `eng_in_final_o` is the selected segment-end flag ANDed with `absorb_last_i`. Engine output is never accepted while absorbing.
- R7: While squeezing, only the sink chosen by the mode receives `eng_out_valid_i`: mode 0 the uniform sink, mode 1 the noise sink, modes 2 to 4 the bypass sink. `eng_out_ready_o` is that sink's ready, and the readies of the other sinks have no effect.
- R8: In modes 0, 1 and 4 the job emits ceil(`xof_len_i`/8) beats. On each beat, byte lane b of `snk_keep_o` is set when more than b bytes remain. `snk_last_o` marks the beat with at most 8 bytes remaining. A length of 0 ends the job when absorption ends, with no output beats.
- R9: Mode 2 emits 32 bytes (4 beats) and mode 3 emits 64 bytes (8 beats), whatever `xof_len_i` holds.
- R10: `done_o` rises on the cycle after the job's final handshake and stays high until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle job start |
| mode_i | input | 3 | Job mode code, sampled with start |
| src_sel_i | input | 2 | Input source code, sampled with start |
| xof_len_i | input | 16 | Output length in bytes for extendable-output modes |
| absorb_last_i | input | 1 | Current segment is the final absorb segment |
| seed_data_i | input | 64 | Seed memory beat |
| seed_valid_i | input | 1 | Seed beat valid |
| seed_last_i | input | 1 | Seed beat ends a segment |
| seed_ready_o | output | 1 | Seed beat accepted |
| poly_data_i | input | 64 | Polynomial reader beat |
| poly_valid_i | input | 1 | Polynomial beat valid |
| poly_last_i | input | 1 | Polynomial beat ends a segment |
| poly_ready_o | output | 1 | Polynomial beat accepted |
| raw_data_i | input | 64 | Raw stream beat |
| raw_valid_i | input | 1 | Raw beat valid |
| raw_last_i | input | 1 | Raw beat ends a segment |
| raw_ready_o | output | 1 | Raw beat accepted |
| eng_cfg_o | output | 2 | Engine function select |
| eng_in_data_o | output | 64 | Absorb data to engine |
| eng_in_valid_o | output | 1 | Absorb data valid |
| eng_in_seg_end_o | output | 1 | Absorb beat ends a segment |
| eng_in_final_o | output | 1 | Absorb segment is the final one |
| eng_in_ready_i | input | 1 | Engine accepts absorb beat |
| eng_out_data_i | input | 64 | Squeezed beat from engine |
| eng_out_valid_i | input | 1 | Squeezed beat valid |
| eng_out_ready_o | output | 1 | Squeezed beat taken |
| snk_data_o | output | 64 | Squeezed beat to sinks |
| snk_keep_o | output | 8 | Valid byte lanes of the beat |
| snk_last_o | output | 1 | Final beat of the job |
| uni_valid_o | output | 1 | Beat valid to uniform sampler |
| uni_ready_i | input | 1 | Uniform sampler ready |
| noise_valid_o | output | 1 | Beat valid to noise sampler |
| noise_ready_i | input | 1 | Noise sampler ready |
| byp_valid_o | output | 1 | Beat valid to bypass write port |
| byp_ready_i | input | 1 | Bypass write port ready |
| done_o | output | 1 | Sticky job-complete flag |

## Verification
The start input and the job's final output handshake can meet in one cycle. That start must be ignored, so the next cycle shows done high with the old configuration still in place. A second start then arrives while done is high. Also, a segment-end beat can arrive with absorb-last high in the same cycle that the engine offers output. The bench sets the source, engine and sink handshakes from a pseudo-random sequence so that these overlaps occur on their own. It also injects starts during busy jobs and illegal starts while done is high. A behavioural model of phase, remaining bytes and done predicts every output on every clock.

// File: rtl/hs_route_pkg.sv
// Shared codes for the hash-sampler router: mode codes, source codes,
// engine function select, sink select and sequencer phase.
package hs_route_pkg;
    localparam int DATA_W  = 64;
    localparam int LEN_W   = 16;
    localparam int NUM_SRC = 3;
    localparam int NUM_SNK = 3;
    localparam int SEL_W   = $clog2(NUM_SRC);
    localparam int BYTES   = DATA_W / 8;

    localparam logic [2:0] MODE_UNIFORM = 3'd0;
    localparam logic [2:0] MODE_NOISE   = 3'd1;
    localparam logic [2:0] MODE_H256    = 3'd2;
    localparam logic [2:0] MODE_H512    = 3'd3;
    localparam logic [2:0] MODE_XOF256  = 3'd4;

    typedef enum logic [1:0] {
        KC_SHAKE128 = 2'd0,
        KC_SHAKE256 = 2'd1,
        KC_SHA3_256 = 2'd2,
        KC_SHA3_512 = 2'd3
    } kc_cfg_e;

    typedef enum logic [1:0] {
        SNK_UNI   = 2'd0,
        SNK_NOISE = 2'd1,
        SNK_BYP   = 2'd2
    } snk_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ABSORB  = 2'd1,
        ST_SQUEEZE = 2'd2
    } seq_st_e;
endpackage

// File: rtl/hs_mode_decode.sv
// Mode decoder: turns a requested mode code into the engine function,
// the squeeze sink, the legality of the code and, for fixed-output
// hashes, the output length. Purely combinational.
module hs_mode_decode
    import hs_route_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic [2:0]    mode_i,
    input  logic [LW-1:0] xof_len_i,
    output kc_cfg_e       cfg_o,
    output snk_sel_e      sink_o,
    output logic [LW-1:0] len_o,
    output logic          legal_o
);
    // Table lookup of function, sink and job length per mode.
    always_comb begin
        legal_o = 1'b1;
        cfg_o   = KC_SHAKE128;
        sink_o  = SNK_UNI;
        len_o   = xof_len_i;
        case (mode_i)
            MODE_UNIFORM: ;
            MODE_NOISE: begin
                cfg_o  = KC_SHAKE256;
                sink_o = SNK_NOISE;
            end
            MODE_H256: begin
                cfg_o  = KC_SHA3_256;
                sink_o = SNK_BYP;
                len_o  = LW'(32);
            end
            MODE_H512: begin
                cfg_o  = KC_SHA3_512;
                sink_o = SNK_BYP;
                len_o  = LW'(64);
            end
            MODE_XOF256: begin
                cfg_o  = KC_SHAKE256;
                sink_o = SNK_BYP;
            end
            default: legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/hs_src_mux.sv
// Absorb-side multiplexer: connects one of NSRC input streams to the
// engine input while active. Unselected sources see ready low.
// Assumes sel_i is held stable for the whole absorb phase.
module hs_src_mux #(
    parameter int DW   = 64,
    parameter int NSRC = 3,
    parameter int SW   = 2
) (
    input  logic                      active_i,
    input  logic [SW-1:0]             sel_i,
    input  logic [NSRC-1:0][DW-1:0]   data_i,
    input  logic [NSRC-1:0]           valid_i,
    input  logic [NSRC-1:0]           last_i,
    input  logic                      eng_ready_i,
    output logic [NSRC-1:0]           ready_o,
    output logic [DW-1:0]             data_o,
    output logic                      valid_o,
    output logic                      seg_end_o
);
    // Forward data, valid and segment end of the selected lane only.
    always_comb begin
        data_o    = '0;
        valid_o   = 1'b0;
        seg_end_o = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (active_i && sel_i == SW'(i)) begin
                data_o    = data_i[i];
                valid_o   = valid_i[i];
                seg_end_o = last_i[i];
            end
        end
    end

    // One ready lane per source, live only for the selected lane.
    for (genvar g = 0; g < NSRC; g++) begin : g_rdy
        assign ready_o[g] = active_i && (sel_i == SW'(g)) && eng_ready_i;
    end
endmodule

// File: rtl/hs_sink_demux.sv
// Squeeze-side demultiplexer: presents the engine's output valid to the
// one selected sink and returns only that sink's ready to the engine.
module hs_sink_demux #(
    parameter int NSNK = 3
) (
    input  logic            active_i,
    input  logic [1:0]      sel_i,
    input  logic            out_valid_i,
    input  logic [NSNK-1:0] sink_ready_i,
    output logic [NSNK-1:0] sink_valid_o,
    output logic            out_ready_o
);
    // Per-sink valid, gated by phase and selection.
    for (genvar g = 0; g < NSNK; g++) begin : g_vld
        assign sink_valid_o[g] = active_i && (sel_i == 2'(g)) && out_valid_i;
    end

    // Return the selected sink's ready; others are ignored.
    always_comb begin
        out_ready_o = 1'b0;
        for (int i = 0; i < NSNK; i++) begin
            if (active_i && sel_i == 2'(i)) out_ready_o = sink_ready_i[i];
        end
    end
endmodule

// File: rtl/hs_seq.sv
// Job sequencer: idle / absorb / squeeze phases, captured job
// settings, remaining-byte counter, keep mask and sticky done.
// Assumes the fire inputs are already qualified by their handshakes.
module hs_seq
    import hs_route_pkg::*;
#(
    parameter int LW = 16,
    parameter int NB = 8,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          start_ok_i,
    input  kc_cfg_e       cfg_i,
    input  snk_sel_e      sink_i,
    input  logic [SW-1:0] src_i,
    input  logic [LW-1:0] len_i,
    input  logic          seg_fire_i,
    input  logic          absorb_last_i,
    input  logic          out_fire_i,
    output seq_st_e       st_o,
    output kc_cfg_e       cfg_o,
    output snk_sel_e      sink_o,
    output logic [SW-1:0] src_o,
    output logic [NB-1:0] keep_o,
    output logic          last_o,
    output logic          done_o
);
    logic [LW-1:0] rem_q;

    // Valid lanes and final-beat flag from the remaining byte count.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            keep_o[b] = (st_o == ST_SQUEEZE) && (rem_q > LW'(b));
        end
        last_o = (st_o == ST_SQUEEZE) && (rem_q <= LW'(NB));
    end

    // Phase transitions, job capture, byte countdown and done latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_o   <= ST_IDLE;
            cfg_o  <= KC_SHAKE128;
            sink_o <= SNK_UNI;
            src_o  <= '0;
            rem_q  <= '0;
            done_o <= 1'b0;
        end else begin
            case (st_o)
                ST_IDLE: begin
                    if (start_i && start_ok_i) begin
                        st_o   <= ST_ABSORB;
                        cfg_o  <= cfg_i;
                        sink_o <= sink_i;
                        src_o  <= src_i;
                        rem_q  <= len_i;
                        done_o <= 1'b0;
                    end
                end
                ST_ABSORB: begin
                    if (seg_fire_i && absorb_last_i) begin
                        if (rem_q == '0) begin
                            st_o   <= ST_IDLE;
                            done_o <= 1'b1;
                        end else begin
                            st_o <= ST_SQUEEZE;
                        end
                    end
                end
                ST_SQUEEZE: begin
                    if (out_fire_i) begin
                        if (last_o) begin
                            st_o   <= ST_IDLE;
                            done_o <= 1'b1;
                        end else begin
                            rem_q <= rem_q - LW'(NB);
                        end
                    end
                end
                default: st_o <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs_router_seq.sv
// Top of the hash-sampler router: decodes the requested mode, sequences
// absorb and squeeze, muxes three input sources to the engine and
// demuxes engine output to the uniform, noise or bypass sink.
// Assumes the engine and sinks use valid/ready handshakes.
module hs_router_seq
    import hs_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        mode_i,
    input  logic [SEL_W-1:0]  src_sel_i,
    input  logic [LEN_W-1:0]  xof_len_i,
    input  logic              absorb_last_i,
    input  logic [DATA_W-1:0] seed_data_i,
    input  logic              seed_valid_i,
    input  logic              seed_last_i,
    output logic              seed_ready_o,
    input  logic [DATA_W-1:0] poly_data_i,
    input  logic              poly_valid_i,
    input  logic              poly_last_i,
    output logic              poly_ready_o,
    input  logic [DATA_W-1:0] raw_data_i,
    input  logic              raw_valid_i,
    input  logic              raw_last_i,
    output logic              raw_ready_o,
    output logic [1:0]        eng_cfg_o,
    output logic [DATA_W-1:0] eng_in_data_o,
    output logic              eng_in_valid_o,
    output logic              eng_in_seg_end_o,
    output logic              eng_in_final_o,
    input  logic              eng_in_ready_i,
    input  logic [DATA_W-1:0] eng_out_data_i,
    input  logic              eng_out_valid_i,
    output logic              eng_out_ready_o,
    output logic [DATA_W-1:0] snk_data_o,
    output logic [BYTES-1:0]  snk_keep_o,
    output logic              snk_last_o,
    output logic              uni_valid_o,
    input  logic              uni_ready_i,
    output logic              noise_valid_o,
    input  logic              noise_ready_i,
    output logic              byp_valid_o,
    input  logic              byp_ready_i,
    output logic              done_o
);
    kc_cfg_e                         new_cfg, cur_cfg;
    snk_sel_e                        new_sink, cur_sink;
    seq_st_e                         st;
    logic [LEN_W-1:0]                new_len;
    logic                            mode_ok, src_ok;
    logic [SEL_W-1:0]                cur_src;
    logic [NUM_SRC-1:0][DATA_W-1:0]  src_data;
    logic [NUM_SRC-1:0]              src_valid, src_last, src_ready;
    logic [NUM_SNK-1:0]              snk_valid, snk_ready;

    // Gather sources and sinks into index-ordered lanes.
    assign src_data  = {raw_data_i, poly_data_i, seed_data_i};
    assign src_valid = {raw_valid_i, poly_valid_i, seed_valid_i};
    assign src_last  = {raw_last_i, poly_last_i, seed_last_i};
    assign {raw_ready_o, poly_ready_o, seed_ready_o} = src_ready;
    assign snk_ready = {byp_ready_i, noise_ready_i, uni_ready_i};
    assign {byp_valid_o, noise_valid_o, uni_valid_o} = snk_valid;
    assign src_ok    = src_sel_i < SEL_W'(NUM_SRC);
    assign eng_cfg_o = cur_cfg;
    assign snk_data_o     = eng_out_data_i;
    assign eng_in_final_o = eng_in_seg_end_o && absorb_last_i;

    hs_mode_decode #(.LW(LEN_W)) u_dec (
        .mode_i    (mode_i),
        .xof_len_i (xof_len_i),
        .cfg_o     (new_cfg),
        .sink_o    (new_sink),
        .len_o     (new_len),
        .legal_o   (mode_ok)
    );

    hs_seq #(.LW(LEN_W), .NB(BYTES), .SW(SEL_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .start_ok_i    (mode_ok && src_ok),
        .cfg_i         (new_cfg),
        .sink_i        (new_sink),
        .src_i         (src_sel_i),
        .len_i         (new_len),
        .seg_fire_i    (eng_in_valid_o && eng_in_ready_i && eng_in_seg_end_o),
        .absorb_last_i (absorb_last_i),
        .out_fire_i    (eng_out_valid_i && eng_out_ready_o),
        .st_o          (st),
        .cfg_o         (cur_cfg),
        .sink_o        (cur_sink),
        .src_o         (cur_src),
        .keep_o        (snk_keep_o),
        .last_o        (snk_last_o),
        .done_o        (done_o)
    );

    hs_src_mux #(.DW(DATA_W), .NSRC(NUM_SRC), .SW(SEL_W)) u_mux (
        .active_i    (st == ST_ABSORB),
        .sel_i       (cur_src),
        .data_i      (src_data),
        .valid_i     (src_valid),
        .last_i      (src_last),
        .eng_ready_i (eng_in_ready_i),
        .ready_o     (src_ready),
        .data_o      (eng_in_data_o),
        .valid_o     (eng_in_valid_o),
        .seg_end_o   (eng_in_seg_end_o)
    );

    hs_sink_demux #(.NSNK(NUM_SNK)) u_demux (
        .active_i     (st == ST_SQUEEZE),
        .sel_i        (cur_sink),
        .out_valid_i  (eng_out_valid_i),
        .sink_ready_i (snk_ready),
        .sink_valid_o (snk_valid),
        .out_ready_o  (eng_out_ready_o)
    );
endmodule

// File: rtl/hs_router_seq_chk.sv
// Property checker for hs_router_seq, attached by bind below.
module hs_router_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       done_o,
    input logic       eng_in_valid_o,
    input logic       eng_out_ready_o,
    input logic       eng_out_valid_i,
    input logic       uni_valid_o,
    input logic       noise_valid_o,
    input logic       byp_valid_o,
    input logic       seed_ready_o,
    input logic       poly_ready_o,
    input logic       raw_ready_o,
    input logic [1:0] eng_cfg_o
);
    AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({uni_valid_o, noise_valid_o, byp_valid_o})); // R7
    AST_NO_GHOST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (uni_valid_o || noise_valid_o || byp_valid_o) |-> eng_out_valid_i); // R7
    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seed_ready_o, poly_ready_o, raw_ready_o})); // R5
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_in_valid_o && eng_out_ready_o)); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R10
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(eng_cfg_o)); // R3
endmodule

bind hs_router_seq hs_router_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .done_o          (done_o),
    .eng_in_valid_o  (eng_in_valid_o),
    .eng_out_ready_o (eng_out_ready_o),
    .eng_out_valid_i (eng_out_valid_i),
    .uni_valid_o     (uni_valid_o),
    .noise_valid_o   (noise_valid_o),
    .byp_valid_o     (byp_valid_o),
    .seed_ready_o    (seed_ready_o),
    .poly_ready_o    (poly_ready_o),
    .raw_ready_o     (raw_ready_o),
    .eng_cfg_o       (eng_cfg_o)
);

// File: tb/hs_router_seq_bench.sv
`timescale 1ns/1ps
module hs_router_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [1:0]  src_sel_i = 2'd0;
    logic [15:0] xof_len_i = 16'd0;
    logic        absorb_last_i = 1'b0;
    logic [63:0] seed_data_i = '0, poly_data_i = '0, raw_data_i = '0;
    logic        seed_valid_i = 0, seed_last_i = 0, poly_valid_i = 0;
    logic        poly_last_i = 0, raw_valid_i = 0, raw_last_i = 0;
    logic        seed_ready_o, poly_ready_o, raw_ready_o;
    logic [1:0]  eng_cfg_o;
    logic [63:0] eng_in_data_o;
    logic        eng_in_valid_o, eng_in_seg_end_o, eng_in_final_o;
    logic        eng_in_ready_i = 0;
    logic [63:0] eng_out_data_i = '0;
    logic        eng_out_valid_i = 0, eng_out_ready_o;
    logic [63:0] snk_data_o;
    logic [7:0]  snk_keep_o;
    logic        snk_last_o, uni_valid_o, noise_valid_o, byp_valid_o;
    logic        uni_ready_i = 0, noise_ready_i = 0, byp_ready_i = 0;
    logic        done_o;

    int checks = 0, errors = 0, cyc = 0;
    int m_st = 0, m_cfg = 0, m_sink = 0, m_src = 0, m_rem = 0, m_done = 0;
    int m_segs = 0, want_segs = 0, dut_beats = 0;
    logic [31:0] lfsr = 32'h1ACE_5EED;

    always #2.5 clk = ~clk;

    hs_router_seq u_hs_router_seq (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model: phase, captured job, remaining bytes, done.
    always @(posedge clk) begin
        logic [2:0] sv, sl, sr;
        sv = {raw_valid_i, poly_valid_i, seed_valid_i};
        sl = {raw_last_i, poly_last_i, seed_last_i};
        sr = {byp_ready_i, noise_ready_i, uni_ready_i};
        if (!rst_n) begin
            m_st = 0; m_cfg = 0; m_sink = 0; m_src = 0; m_rem = 0; m_done = 0;
        end else if (m_st == 0) begin
            if (start_i && mode_i <= 4 && src_sel_i <= 2) begin
                m_st = 1; m_src = src_sel_i; m_done = 0; m_segs = 0;
                m_cfg  = (mode_i == 4) ? 1 : int'(mode_i);
                m_sink = (mode_i >= 2) ? 2 : int'(mode_i);
                m_rem  = (mode_i == 2) ? 32 : (mode_i == 3) ? 64 : int'(xof_len_i);
            end
        end else if (m_st == 1) begin
            if (sv[m_src] && eng_in_ready_i && sl[m_src]) begin
                if (absorb_last_i) begin
                    if (m_rem == 0) begin m_st = 0; m_done = 1; end
                    else m_st = 2;
                end else m_segs++;
            end
        end else begin
            if (eng_out_valid_i && sr[m_sink]) begin
                if (m_rem <= 8) begin m_st = 0; m_done = 1; end
                else m_rem -= 8;
            end
        end
    end

    // Pseudo-random handshakes and data, changed just after each edge.
    always @(posedge clk) begin
        #1;
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        seed_valid_i = lfsr[0]; poly_valid_i = lfsr[1]; raw_valid_i = lfsr[2];
        seed_last_i = lfsr[3] & lfsr[4]; poly_last_i = lfsr[5] & lfsr[6];
        raw_last_i = lfsr[7] & lfsr[8];
        seed_data_i = {32'h5EED_0000, lfsr};
        poly_data_i = {32'hB017_0000, ~lfsr};
        raw_data_i  = {lfsr, 32'h4A40_0000};
        eng_in_ready_i = lfsr[9] | lfsr[10];
        eng_out_valid_i = lfsr[11] | lfsr[12];
        eng_out_data_i = {lfsr, lfsr ^ 32'h0F0F_0F0F};
        uni_ready_i = lfsr[13]; noise_ready_i = lfsr[14] | lfsr[15];
        byp_ready_i = lfsr[16];
        absorb_last_i = (m_segs >= want_segs) && lfsr[17];
    end

    // Per-clock comparison of every output against the model.
    always @(negedge clk) begin
        logic [2:0] sv, sl, sr, e_rdy, e_snk;
        logic [63:0] e_dat;
        logic [7:0] e_keep;
        sv = {raw_valid_i, poly_valid_i, seed_valid_i};
        sl = {raw_last_i, poly_last_i, seed_last_i};
        sr = {byp_ready_i, noise_ready_i, uni_ready_i};
        e_dat = (m_src == 0) ? seed_data_i : (m_src == 1) ? poly_data_i : raw_data_i;
        if (m_st != 1) e_dat = '0;
        e_rdy = (m_st == 1 && eng_in_ready_i) ? (3'b001 << m_src) : 3'b000;
        e_snk = (m_st == 2 && eng_out_valid_i) ? (3'b001 << m_sink) : 3'b000;
        for (int b = 0; b < 8; b++) e_keep[b] = (m_st == 2) && (m_rem > b);
        if (rst_n) begin
            chk(done_o == m_done, "R10", "done", done_o, m_done);
            chk(eng_cfg_o == m_cfg, "R4", "cfg", eng_cfg_o, m_cfg);
            chk({raw_ready_o, poly_ready_o, seed_ready_o} == e_rdy, "R5", "src ready",
                {raw_ready_o, poly_ready_o, seed_ready_o}, e_rdy);
            chk(eng_in_data_o == e_dat, "R5", "eng data", eng_in_data_o, e_dat);
            chk(eng_in_valid_o == (m_st == 1 && sv[m_src]), "R5", "eng valid",
                eng_in_valid_o, (m_st == 1 && sv[m_src]));
            chk(eng_in_final_o == (m_st == 1 && sl[m_src] && absorb_last_i), "R6",
                "final", eng_in_final_o, (m_st == 1 && sl[m_src] && absorb_last_i));
            chk({byp_valid_o, noise_valid_o, uni_valid_o} == e_snk, "R7", "sink valid",
                {byp_valid_o, noise_valid_o, uni_valid_o}, e_snk);
            chk(eng_out_ready_o == (m_st == 2 && sr[m_sink]), "R7", "out ready",
                eng_out_ready_o, (m_st == 2 && sr[m_sink]));
            chk(snk_keep_o == e_keep, "R8", "keep", snk_keep_o, e_keep);
            chk(snk_last_o == (m_st == 2 && m_rem <= 8), "R8", "last",
                snk_last_o, (m_st == 2 && m_rem <= 8));
            if ((uni_valid_o && uni_ready_i) || (noise_valid_o && noise_ready_i) ||
                (byp_valid_o && byp_ready_i)) dut_beats++;
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; errors++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_op(input logic [2:0] md, input logic [1:0] src,
                          input int len, input int segs, input int beats,
                          input string req, input bit intrude);
        want_segs = segs;
        @(posedge clk); #1;
        mode_i = md; src_sel_i = src; xof_len_i = 16'(len); start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        dut_beats = 0;
        @(negedge clk);
        chk(done_o == 1'b0, "R2", "done cleared by start", done_o, 0);
        if (intrude) begin
            @(posedge clk); #1;
            mode_i = 3'd3; src_sel_i = 2'd0; start_i = 1'b1;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        for (int i = 0; i < 20000 && !done_o; i++) @(negedge clk);
        chk(dut_beats == beats, req, "beat count", dut_beats, beats);
        repeat (3) @(negedge clk);
        chk(done_o == 1'b1, "R10", "done held", done_o, 1);
    endtask

    task automatic bad_start(input logic [2:0] md, input logic [1:0] src);
        logic [1:0] cfg0;
        cfg0 = eng_cfg_o;
        @(posedge clk); #1;
        mode_i = md; src_sel_i = src; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(done_o == 1'b1, "R2", "illegal start keeps done", done_o, 1);
        chk(eng_cfg_o == cfg0, "R2", "illegal start keeps cfg", eng_cfg_o, cfg0);
        chk(eng_in_valid_o == 1'b0 && seed_ready_o == 0 && poly_ready_o == 0 && raw_ready_o == 0,
            "R2", "illegal start stays idle", eng_in_valid_o, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done_o == 0, "R1", "reset done", done_o, 0);
        chk(eng_cfg_o == 0, "R1", "reset cfg", eng_cfg_o, 0);
        chk({seed_ready_o, poly_ready_o, raw_ready_o, eng_in_valid_o, eng_out_ready_o,
             uni_valid_o, noise_valid_o, byp_valid_o} == 0, "R1", "reset handshakes",
            {seed_ready_o, poly_ready_o, raw_ready_o, eng_in_valid_o, eng_out_ready_o,
             uni_valid_o, noise_valid_o, byp_valid_o}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        run_op(3'd0, 2'd0, 40, 0, 5, "R8", 1'b0);
        run_op(3'd1, 2'd1, 13, 2, 2, "R8", 1'b0);
        run_op(3'd2, 2'd2, 5, 1, 4, "R9", 1'b0);
        run_op(3'd3, 2'd0, 200, 3, 8, "R9", 1'b0);
        run_op(3'd4, 2'd1, 0, 0, 0, "R8", 1'b0);
        run_op(3'd4, 2'd2, 24, 1, 3, "R3", 1'b1);
        bad_start(3'd6, 2'd0);
        bad_start(3'd1, 2'd3);
        run_op(3'd1, 2'd2, 64, 4, 8, "R7", 1'b0);
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule